// File: doc/BRIEF.md
# Two-Phase Shared-Port RISC Core

This block is a compact 32-bit processor for a subset of a classic three-register load/store instruction set. It never overlaps work: a fetch phase reads the next instruction word, and an execute phase decodes it, reads the register file, computes the result or memory address, resolves any change of flow and writes back. The core has one memory port, and both phases use it. Because only one phase is active at a time, instruction fetch and data access never compete for that port.

The fetched word and the address it came from are held in an instruction holding register between the two phases. The program counter moves only at the end of execute. A debug output exposes the current program counter. The memory behind the port must return read data in the same cycle as the request. The core captures that data at the clock edge that closes the cycle.

Top module: `twostep_core`

## Requirements
- R1: After reset the core is in the fetch phase with the program counter at RESET_PC (default 0). After that the phase alternates every cycle: fetch, execute, fetch, and so on.
- R2: In a fetch cycle the port issues a read (request 1, write enable 0) at the program counter. The program counter does not change, and the returned word is stored with that program counter for the following execute cycle.
- R3: In an execute cycle the port is requested only by a load (opcode 0x23, read) or a store (opcode 0x2B, write). For every other instruction the request is 0.
- R4: At the end of execute the program counter becomes the change-of-flow target when one is taken. Otherwise it becomes the stored program counter + 4.
- R5: BEQ (opcode 0x04) is taken when rs equals rt, and BNE (opcode 0x05) is taken when they differ. With rt = register 0 this is a zero test. The target is the stored program counter plus the sign-extended 16-bit offset shifted left by 2, so negative offsets go backwards.
- R6: J (opcode 0x02) and JAL (opcode 0x03) go to {stored PC[31:28], index field [25:0], 2'b00}. JR (opcode 0, funct 0x08) and JALR (opcode 0, funct 0x09) go to the value of rs.
- R7: JAL and JALR write the stored program counter + 4 into register 31.
- R8: Register-form ALU operations (opcode 0) take rs and rt and write rd: funct 0x21/0x20 add, 0x23/0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A signed set-less-than, 0x2B unsigned set-less-than. The shifts 0x00 (left logical), 0x02 (right logical) and 0x03 (right arithmetic) shift rt by bits [10:6].
- R9: Immediate ALU operations write rt. The add 0x09, signed compare 0x0A and unsigned compare 0x0B sign-extend bits [15:0]. The and 0x0C, or 0x0D and xor 0x0E zero-extend them. Opcode 0x0F places the immediate in the upper half of rt with zeros below.
- R10: Loads and stores address rs + the sign-extended immediate. A load writes the returned word to rt. A store sends the value of rt as write data and leaves the register file unchanged.
- R11: Register 0 reads as zero, and any write aimed at it is dropped.
- R12: Read data is taken at the clock edge that ends the request cycle. The fetched word and the loaded word both come from the same cycle as their request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data for this cycle's request |
| dbg_pc | output | 32 | Current program counter |

## Verification
The bench builds the core with its default parameters: 32-bit data, 32 registers, register 0 hard-wired and set-less-than taken from the subtractor. This keeps the operand space small enough to sweep. Every register-form operation runs against every pair of five edge-case operands (0, 1, largest positive, most negative, all ones). Every immediate operation runs against those operands and five immediates that straddle the sign bit. The shifts use amounts of 4 and 31. Hand-built sequences then cover:
- forward and backward branches, both taken and not taken;
- absolute and register jumps with their link values;
- writes aimed at register 0;
- loads and stores with negative offsets.

The bench computes every expected value arithmetically.

// File: rtl/twostep_pkg.sv
package twostep_pkg;

   typedef enum logic {
      ST_FETCH = 1'b0,
      ST_EXEC  = 1'b1
   } stage_e;

   typedef enum logic [3:0] {
      AL_ADD, AL_SUB, AL_AND, AL_OR, AL_XOR, AL_NOR,
      AL_SLT, AL_SLTU, AL_SLL, AL_SRL, AL_SRA, AL_LUI
   } alu_op_e;

   typedef enum logic [2:0] {
      K_NONE, K_ALU, K_LOAD, K_STORE, K_BRANCH, K_JABS, K_JREG
   } kind_e;

   typedef enum logic [1:0] {
      DST_NONE, DST_RT, DST_RD, DST_LINK
   } dst_e;

   typedef struct packed {
      kind_e      kind;
      alu_op_e    alu;
      dst_e       dst;
      logic       use_imm;
      logic       zext;
      logic       br_ne;
      logic [4:0] rs;
      logic [4:0] rt;
      logic [4:0] rd;
      logic [4:0] shamt;
      logic [15:0] imm16;
      logic [25:0] index;
   } dec_t;

   // primary opcodes
   localparam logic [5:0] OPC_SPECIAL = 6'h00;
   localparam logic [5:0] OPC_J       = 6'h02;
   localparam logic [5:0] OPC_JAL     = 6'h03;
   localparam logic [5:0] OPC_BEQ     = 6'h04;
   localparam logic [5:0] OPC_BNE     = 6'h05;
   localparam logic [5:0] OPC_ADDIU   = 6'h09;
   localparam logic [5:0] OPC_SLTI    = 6'h0A;
   localparam logic [5:0] OPC_SLTIU   = 6'h0B;
   localparam logic [5:0] OPC_ANDI    = 6'h0C;
   localparam logic [5:0] OPC_ORI     = 6'h0D;
   localparam logic [5:0] OPC_XORI    = 6'h0E;
   localparam logic [5:0] OPC_LUI     = 6'h0F;
   localparam logic [5:0] OPC_LW      = 6'h23;
   localparam logic [5:0] OPC_SW      = 6'h2B;

   // register-form function codes
   localparam logic [5:0] FN_SLL  = 6'h00;
   localparam logic [5:0] FN_SRL  = 6'h02;
   localparam logic [5:0] FN_SRA  = 6'h03;
   localparam logic [5:0] FN_JR   = 6'h08;
   localparam logic [5:0] FN_JALR = 6'h09;
   localparam logic [5:0] FN_ADD  = 6'h20;
   localparam logic [5:0] FN_ADDU = 6'h21;
   localparam logic [5:0] FN_SUB  = 6'h22;
   localparam logic [5:0] FN_SUBU = 6'h23;
   localparam logic [5:0] FN_AND  = 6'h24;
   localparam logic [5:0] FN_OR   = 6'h25;
   localparam logic [5:0] FN_XOR  = 6'h26;
   localparam logic [5:0] FN_NOR  = 6'h27;
   localparam logic [5:0] FN_SLT  = 6'h2A;
   localparam logic [5:0] FN_SLTU = 6'h2B;

endpackage

// File: rtl/twostep_decode.sv
module twostep_decode
   import twostep_pkg::*;
(
   input  logic [31:0] instr,
   output dec_t        dec
);

   logic [5:0] opc;
   logic [5:0] fn;
   alu_op_e    r_op;
   logic       r_alu_ok;

   assign opc = instr[31:26];
   assign fn  = instr[5:0];

   // register-form ALU function table
   always_comb begin
      r_op     = AL_ADD;
      r_alu_ok = 1'b1;
      case (fn)
         FN_SLL:            r_op = AL_SLL;
         FN_SRL:            r_op = AL_SRL;
         FN_SRA:            r_op = AL_SRA;
         FN_ADD, FN_ADDU:   r_op = AL_ADD;
         FN_SUB, FN_SUBU:   r_op = AL_SUB;
         FN_AND:            r_op = AL_AND;
         FN_OR:             r_op = AL_OR;
         FN_XOR:            r_op = AL_XOR;
         FN_NOR:            r_op = AL_NOR;
         FN_SLT:            r_op = AL_SLT;
         FN_SLTU:           r_op = AL_SLTU;
         default:           r_alu_ok = 1'b0;
      endcase
   end

   always_comb begin
      dec         = '0;
      dec.kind    = K_NONE;
      dec.alu     = AL_ADD;
      dec.dst     = DST_NONE;
      dec.rs      = instr[25:21];
      dec.rt      = instr[20:16];
      dec.rd      = instr[15:11];
      dec.shamt   = instr[10:6];
      dec.imm16   = instr[15:0];
      dec.index   = instr[25:0];
      case (opc)
         OPC_SPECIAL: begin
            if (fn == FN_JR) begin
               dec.kind = K_JREG;
            end else if (fn == FN_JALR) begin
               dec.kind = K_JREG;
               dec.dst  = DST_LINK;
            end else if (r_alu_ok) begin
               dec.kind = K_ALU;
               dec.alu  = r_op;
               dec.dst  = DST_RD;
            end
         end
         OPC_J:   dec.kind = K_JABS;
         OPC_JAL: begin
            dec.kind = K_JABS;
            dec.dst  = DST_LINK;
         end
         OPC_BEQ: dec.kind = K_BRANCH;
         OPC_BNE: begin
            dec.kind  = K_BRANCH;
            dec.br_ne = 1'b1;
         end
         OPC_ADDIU, OPC_SLTI, OPC_SLTIU, OPC_ANDI, OPC_ORI, OPC_XORI, OPC_LUI: begin
            dec.kind    = K_ALU;
            dec.dst     = DST_RT;
            dec.use_imm = 1'b1;
            case (opc)
               OPC_ADDIU: dec.alu = AL_ADD;
               OPC_SLTI:  dec.alu = AL_SLT;
               OPC_SLTIU: dec.alu = AL_SLTU;
               OPC_ANDI:  begin dec.alu = AL_AND; dec.zext = 1'b1; end
               OPC_ORI:   begin dec.alu = AL_OR;  dec.zext = 1'b1; end
               OPC_XORI:  begin dec.alu = AL_XOR; dec.zext = 1'b1; end
               default:   begin dec.alu = AL_LUI; dec.zext = 1'b1; end
            endcase
         end
         OPC_LW: begin
            dec.kind = K_LOAD;
            dec.dst  = DST_RT;
         end
         OPC_SW: dec.kind = K_STORE;
         default: dec.kind = K_NONE;
      endcase
   end

endmodule

// File: rtl/twostep_alu.sv
module twostep_alu
   import twostep_pkg::*;
#(
   parameter int W            = 32,
   parameter bit SLT_FROM_SUB = 1'b1,
   localparam int SH_W        = $clog2(W)
) (
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   input  logic [SH_W-1:0] shamt,
   input  alu_op_e         op,
   output logic [W-1:0]    y
);

   logic lt_signed;
   logic lt_unsigned;

   generate
      if (SLT_FROM_SUB) begin : g_cmp_sub
         logic [W:0] diff_u;
         assign diff_u      = {1'b0, a} - {1'b0, b};
         assign lt_unsigned = diff_u[W];
         assign lt_signed   = (a[W-1] ^ b[W-1]) ? a[W-1] : diff_u[W-1];
      end else begin : g_cmp_direct
         assign lt_unsigned = (a < b);
         assign lt_signed   = ($signed(a) < $signed(b));
      end
   endgenerate

   always_comb begin
      case (op)
         AL_ADD:  y = a + b;
         AL_SUB:  y = a - b;
         AL_AND:  y = a & b;
         AL_OR:   y = a | b;
         AL_XOR:  y = a ^ b;
         AL_NOR:  y = ~(a | b);
         AL_SLT:  y = {{(W-1){1'b0}}, lt_signed};
         AL_SLTU: y = {{(W-1){1'b0}}, lt_unsigned};
         AL_SLL:  y = b << shamt;
         AL_SRL:  y = b >> shamt;
         AL_SRA:  y = W'($signed(b) >>> shamt);
         AL_LUI:  y = b << (W / 2);
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/twostep_regfile.sv
module twostep_regfile #(
   parameter int W          = 32,
   parameter int NREGS      = 32,
   parameter bit HARD_ZERO  = 1'b1,
   localparam int IDX_W     = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ra_a,
   input  logic [IDX_W-1:0] ra_b,
   output logic [W-1:0]     rd_a,
   output logic [W-1:0]     rd_b,
   input  logic             we,
   input  logic [IDX_W-1:0] wa,
   input  logic [W-1:0]     wd
);

   logic [W-1:0] regs [NREGS];
   logic         we_eff;

   generate
      if (HARD_ZERO) begin : g_zero
         assign we_eff = we && (wa != '0);
         assign rd_a   = (ra_a == '0) ? '0 : regs[ra_a];
         assign rd_b   = (ra_b == '0) ? '0 : regs[ra_b];
      end else begin : g_plain
         assign we_eff = we;
         assign rd_a   = regs[ra_a];
         assign rd_b   = regs[ra_b];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (we_eff) begin
         regs[wa] <= wd;
      end
   end

endmodule

// File: rtl/twostep_core.sv
module twostep_core
   import twostep_pkg::*;
#(
   parameter int          DATA_W       = 32,
   parameter int          NREGS        = 32,
   parameter logic [31:0] RESET_PC     = 32'h0000_0000,
   parameter int          LINK_REG     = 31,
   parameter bit          SLT_FROM_SUB = 1'b1,
   parameter bit          HARD_ZERO    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata,
   output logic [31:0] dbg_pc
);

   localparam int IDX_W = $clog2(NREGS);
   localparam int SH_W  = $clog2(DATA_W);
   localparam int IMM_W = DATA_W / 2;

   // elaboration-time parameter checks
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("twostep_core: DATA_W must be 32");
      end
      if (NREGS != 32) begin : g_bad_regs
         $error("twostep_core: NREGS must be 32");
      end
      if (LINK_REG <= 0 || LINK_REG >= NREGS) begin : g_bad_link
         $error("twostep_core: LINK_REG out of range");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset_pc
         $error("twostep_core: RESET_PC must be word aligned");
      end
   endgenerate

   // sequencer state and instruction holding register
   stage_e            stage_q;
   logic [DATA_W-1:0] pc_q;
   logic [DATA_W-1:0] ir_pc_q;
   logic [31:0]       ir_word_q;
   logic              in_exec;

   assign in_exec = (stage_q == ST_EXEC);

   // decode
   dec_t dec;
   twostep_decode u_dec (
      .instr (ir_word_q),
      .dec   (dec)
   );

   // register file
   logic [DATA_W-1:0] rs_val;
   logic [DATA_W-1:0] rt_val;
   logic              rf_we;
   logic [IDX_W-1:0]  rf_wa;
   logic [DATA_W-1:0] rf_wd;

   twostep_regfile #(
      .W         (DATA_W),
      .NREGS     (NREGS),
      .HARD_ZERO (HARD_ZERO)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra_a  (IDX_W'(dec.rs)),
      .ra_b  (IDX_W'(dec.rt)),
      .rd_a  (rs_val),
      .rd_b  (rt_val),
      .we    (rf_we),
      .wa    (rf_wa),
      .wd    (rf_wd)
   );

   // immediate extension
   logic [DATA_W-1:0] imm_sext;
   logic [DATA_W-1:0] imm_zext;
   logic [DATA_W-1:0] imm_alu;

   assign imm_sext = {{(DATA_W-IMM_W){dec.imm16[IMM_W-1]}}, dec.imm16};
   assign imm_zext = {{(DATA_W-IMM_W){1'b0}}, dec.imm16};
   assign imm_alu  = dec.zext ? imm_zext : imm_sext;

   // ALU
   logic [DATA_W-1:0] alu_b;
   logic [DATA_W-1:0] alu_y;

   assign alu_b = dec.use_imm ? imm_alu : rt_val;

   twostep_alu #(
      .W            (DATA_W),
      .SLT_FROM_SUB (SLT_FROM_SUB)
   ) u_alu (
      .a     (rs_val),
      .b     (alu_b),
      .shamt (SH_W'(dec.shamt)),
      .op    (dec.alu),
      .y     (alu_y)
   );

   // address and change-of-flow logic
   logic [DATA_W-1:0] eff_addr;
   logic [DATA_W-1:0] seq_pc;
   logic [DATA_W-1:0] target_pc;
   logic              cond_true;
   logic              taken;
   logic              is_mem;

   assign eff_addr  = rs_val + imm_sext;
   assign seq_pc    = ir_pc_q + DATA_W'(4);
   assign cond_true = (rs_val == rt_val) ^ dec.br_ne;
   assign is_mem    = (dec.kind == K_LOAD) || (dec.kind == K_STORE);

   always_comb begin
      case (dec.kind)
         K_BRANCH: target_pc = ir_pc_q + (imm_sext << 2);
         K_JABS:   target_pc = {ir_pc_q[DATA_W-1:28], dec.index, 2'b00};
         K_JREG:   target_pc = rs_val;
         default:  target_pc = seq_pc;
      endcase
   end

   always_comb begin
      case (dec.kind)
         K_BRANCH:       taken = cond_true;
         K_JABS, K_JREG: taken = 1'b1;
         default:        taken = 1'b0;
      endcase
   end

   // writeback
   always_comb begin
      case (dec.dst)
         DST_RT:   rf_wa = IDX_W'(dec.rt);
         DST_RD:   rf_wa = IDX_W'(dec.rd);
         DST_LINK: rf_wa = IDX_W'(LINK_REG);
         default:  rf_wa = '0;
      endcase
   end

   always_comb begin
      if (dec.dst == DST_LINK)      rf_wd = seq_pc;
      else if (dec.kind == K_LOAD)  rf_wd = mem_rdata;
      else                          rf_wd = alu_y;
   end

   assign rf_we = in_exec && (dec.dst != DST_NONE);

   // shared memory port
   assign mem_req   = !in_exec || is_mem;
   assign mem_we    = in_exec && (dec.kind == K_STORE);
   assign mem_addr  = in_exec ? eff_addr : pc_q;
   assign mem_wdata = rt_val;
   assign dbg_pc    = pc_q;

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q   <= ST_FETCH;
         pc_q      <= RESET_PC;
         ir_pc_q   <= RESET_PC;
         ir_word_q <= '0;
      end else if (!in_exec) begin
         ir_pc_q   <= pc_q;
         ir_word_q <= mem_rdata;
         stage_q   <= ST_EXEC;
      end else begin
         pc_q      <= taken ? target_pc : seq_pc;
         stage_q   <= ST_FETCH;
      end
   end

endmodule

// File: rtl/twostep_checks.sv
module twostep_checks #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_exec,
   input logic [W-1:0] pc,
   input logic [W-1:0] ir_pc,
   input logic [W-1:0] target_pc,
   input logic         taken,
   input logic         is_mem,
   input logic         mem_req,
   input logic         mem_we,
   input logic [31:0]  mem_addr
);

   assert_fetch_then_exec_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_exec |=> in_exec);

   assert_exec_then_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_exec |=> !in_exec);

   assert_fetch_reads_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_exec |-> (mem_req && !mem_we && mem_addr == pc));

   assert_fetch_holds_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_exec |=> pc == $past(pc));

   assert_fetch_latches_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_exec |=> ir_pc == $past(pc));

   assert_exec_port_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && !is_mem) |-> !mem_req);

   assert_write_only_in_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_req && in_exec));

   assert_fallthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && !taken) |=> pc == $past(ir_pc) + W'(4));

   assert_taken_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && taken) |=> pc == $past(target_pc));

endmodule

bind twostep_core twostep_checks #(.W(DATA_W)) u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_exec   (in_exec),
   .pc        (pc_q),
   .ir_pc     (ir_pc_q),
   .target_pc (target_pc),
   .taken     (taken),
   .is_mem    (is_mem),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/sim_twostep_core.sv
module sim_twostep_core;

   localparam int          CLK_PERIOD = 10;
   localparam int          MEM_WORDS  = 4096;
   localparam int          MAX_SLOTS  = 512;
   localparam logic [31:0] RES_BASE   = 32'h0000_2000;
   localparam logic [31:0] CONST_ADDR = 32'h0000_3F00;
   localparam logic [31:0] CONST_VAL  = 32'hCAFE_F00D;

   localparam logic [5:0] O_J = 6'h02, O_JAL = 6'h03, O_BEQ = 6'h04, O_BNE = 6'h05;
   localparam logic [5:0] O_ADDIU = 6'h09, O_SLTI = 6'h0A, O_SLTIU = 6'h0B;
   localparam logic [5:0] O_ANDI = 6'h0C, O_ORI = 6'h0D, O_XORI = 6'h0E, O_LUI = 6'h0F;
   localparam logic [5:0] O_LW = 6'h23, O_SW = 6'h2B;
   localparam logic [5:0] F_SLL = 6'h00, F_SRL = 6'h02, F_SRA = 6'h03;
   localparam logic [5:0] F_JR = 6'h08, F_JALR = 6'h09;
   localparam logic [5:0] F_ADDU = 6'h21, F_SUBU = 6'h23, F_AND = 6'h24, F_OR = 6'h25;
   localparam logic [5:0] F_XOR = 6'h26, F_NOR = 6'h27, F_SLT = 6'h2A, F_SLTU = 6'h2B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic [31:0] dbg_pc;

   always #(CLK_PERIOD / 2) clk = ~clk;

   twostep_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .dbg_pc    (dbg_pc)
   );

   // memory model: program image plus written-word overlay, same-cycle read
   logic [31:0] img   [MEM_WORDS];
   logic [31:0] dmem  [MEM_WORDS];
   logic        wflag [MEM_WORDS];
   logic [11:0] widx;

   assign widx      = mem_addr[13:2];
   assign mem_rdata = wflag[widx] ? dmem[widx] : img[widx];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_WORDS; i++) wflag[i] <= 1'b0;
      end else if (mem_req && mem_we) begin
         dmem[widx]  <= mem_wdata;
         wflag[widx] <= 1'b1;
      end
   end

   function automatic logic [31:0] rd_word(input logic [31:0] a);
      return wflag[a[13:2]] ? dmem[a[13:2]] : img[a[13:2]];
   endfunction

   // encoders
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                         input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt,
                                         input int rd, input int sh);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
   endfunction

   function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [31:0] tgt);
      return {op, tgt[27:2]};
   endfunction

   // arithmetic reference models
   function automatic logic [31:0] r_ref(input logic [5:0] fn, input logic [31:0] a,
                                         input logic [31:0] b, input int sh);
      case (fn)
         F_ADDU:  return a + b;
         F_SUBU:  return a - b;
         F_AND:   return a & b;
         F_OR:    return a | b;
         F_XOR:   return a ^ b;
         F_NOR:   return ~(a | b);
         F_SLT:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         F_SLTU:  return (a < b) ? 32'd1 : 32'd0;
         F_SLL:   return b << sh;
         F_SRL:   return b >> sh;
         default: return 32'($signed(b) >>> sh);
      endcase
   endfunction

   function automatic logic [31:0] i_ref(input logic [5:0] op, input logic [31:0] a,
                                         input logic [15:0] imm);
      logic [31:0] s;
      logic [31:0] z;
      s = {{16{imm[15]}}, imm};
      z = {16'h0000, imm};
      case (op)
         O_ADDIU: return a + s;
         O_SLTI:  return ($signed(a) < $signed(s)) ? 32'd1 : 32'd0;
         O_SLTIU: return (a < s) ? 32'd1 : 32'd0;
         O_ANDI:  return a & z;
         O_ORI:   return a | z;
         default: return a ^ z;
      endcase
   endfunction

   // program construction state
   int          pw;
   int          slot;
   logic [31:0] expv [MAX_SLOTS];
   string       expt [MAX_SLOTS];
   logic [31:0] halt_addr;

   int checks = 0;
   int errors = 0;

   task automatic emit(input logic [31:0] w);
      img[pw] = w;
      pw++;
   endtask

   task automatic store_expect(input int r, input logic [31:0] v, input string t);
      emit(enc_i(O_SW, 0, r, RES_BASE[15:0] + 16'(slot * 4)));
      expv[slot] = v;
      expt[slot] = t;
      slot++;
   endtask

   task automatic load_const(input int r, input logic [31:0] v);
      emit(enc_i(O_LUI, 0, r, v[31:16]));
      emit(enc_i(O_ORI, r, r, v[15:0]));
   endtask

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic build_program();
      logic [31:0] vals [5];
      logic [15:0] imms [5];
      logic [5:0]  rfns [8];
      logic [5:0]  iops [6];
      logic [5:0]  sfns [3];
      int          shs  [2];
      logic [31:0] a;
      logic [31:0] x;
      vals = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
      imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
      rfns = '{F_ADDU, F_SUBU, F_AND, F_OR, F_XOR, F_NOR, F_SLT, F_SLTU};
      iops = '{O_ADDIU, O_SLTI, O_SLTIU, O_ANDI, O_ORI, O_XORI};
      sfns = '{F_SLL, F_SRL, F_SRA};
      shs  = '{4, 31};
      for (int i = 0; i < MEM_WORDS; i++) img[i] = 32'h0;
      img[CONST_ADDR[13:2]] = CONST_VAL;
      pw   = 0;
      slot = 0;

      // R8: register-form sweep over all operand pairs
      for (int i = 0; i < 5; i++) begin
         for (int j = 0; j < 5; j++) begin
            load_const(1, vals[i]);
            load_const(2, vals[j]);
            for (int k = 0; k < 8; k++) begin
               emit(enc_r(rfns[k], 1, 2, 3, 0));
               store_expect(3, r_ref(rfns[k], vals[i], vals[j], 0), "R8");
            end
         end
      end

      // R9 immediate sweep, R8 shifts
      for (int i = 0; i < 5; i++) begin
         load_const(1, vals[i]);
         for (int m = 0; m < 5; m++) begin
            for (int k = 0; k < 6; k++) begin
               emit(enc_i(iops[k], 1, 3, imms[m]));
               store_expect(3, i_ref(iops[k], vals[i], imms[m]), "R9");
            end
         end
         for (int k = 0; k < 3; k++) begin
            for (int s = 0; s < 2; s++) begin
               emit(enc_r(sfns[k], 0, 1, 3, shs[s]));
               store_expect(3, r_ref(sfns[k], 32'h0, vals[i], shs[s]), "R8");
            end
         end
      end
      for (int m = 0; m < 5; m++) begin
         emit(enc_i(O_LUI, 0, 3, imms[m]));
         store_expect(3, {imms[m], 16'h0000}, "R9");
      end

      // R5: zero-test branch taken, skipping one instruction
      emit(enc_i(O_ORI, 0, 5, 16'd1));
      emit(enc_i(O_BEQ, 0, 0, 16'd2));
      emit(enc_i(O_ORI, 0, 5, 16'd2));
      store_expect(5, 32'd1, "R5");
      // R5: zero test on non-zero register falls through
      emit(enc_i(O_ORI, 0, 6, 16'd7));
      emit(enc_i(O_ORI, 0, 5, 16'd1));
      emit(enc_i(O_BEQ, 6, 0, 16'd2));
      emit(enc_i(O_ORI, 0, 5, 16'd2));
      store_expect(5, 32'd2, "R5");
      // R5: BNE taken
      emit(enc_i(O_ORI, 0, 5, 16'd9));
      emit(enc_i(O_BNE, 6, 0, 16'd2));
      emit(enc_i(O_ORI, 0, 5, 16'd3));
      store_expect(5, 32'd9, "R5");
      // R5: BNE on equal registers not taken
      emit(enc_i(O_ORI, 0, 5, 16'd4));
      emit(enc_i(O_BNE, 0, 0, 16'd2));
      emit(enc_i(O_ORI, 0, 5, 16'd8));
      store_expect(5, 32'd8, "R5");
      // R5: backward branch loop, two iterations
      emit(enc_i(O_ORI, 0, 7, 16'd2));
      emit(enc_i(O_ORI, 0, 14, 16'd0));
      emit(enc_i(O_ADDIU, 7, 7, 16'hFFFF));
      emit(enc_i(O_ADDIU, 14, 14, 16'd1));
      emit(enc_i(O_BNE, 7, 0, 16'hFFFE));
      store_expect(7, 32'd0, "R5");
      store_expect(14, 32'd2, "R5");

      // R6/R7: JAL skips two instructions, links
      a = 32'(pw * 4);
      emit(enc_j(O_JAL, a + 32'd12));
      emit(enc_i(O_ORI, 0, 5, 16'h0011));
      emit(enc_i(O_ORI, 0, 5, 16'h0022));
      store_expect(31, a + 32'd4, "R7");
      store_expect(5, 32'd8, "R6");
      // R6: plain J
      a = 32'(pw * 4);
      emit(enc_j(O_J, a + 32'd8));
      emit(enc_i(O_ORI, 0, 5, 16'h0066));
      store_expect(5, 32'd8, "R6");
      // R6/R7: JALR through a register
      x = 32'((pw + 3) * 4);
      emit(enc_i(O_ORI, 0, 8, x[15:0]));
      a = 32'(pw * 4);
      emit(enc_r(F_JALR, 8, 0, 31, 0));
      emit(enc_i(O_ORI, 0, 5, 16'h0033));
      store_expect(31, a + 32'd4, "R7");
      store_expect(5, 32'd8, "R6");
      // R6: JR
      x = 32'((pw + 3) * 4);
      emit(enc_i(O_ORI, 0, 9, x[15:0]));
      emit(enc_r(F_JR, 9, 0, 0, 0));
      emit(enc_i(O_ORI, 0, 5, 16'h0044));
      store_expect(5, 32'd8, "R6");

      // R11: writes to register 0 are dropped
      emit(enc_i(O_ORI, 0, 0, 16'h0055));
      emit(enc_r(F_ADDU, 6, 6, 0, 0));
      store_expect(0, 32'd0, "R11");
      emit(enc_r(F_ADDU, 0, 6, 15, 0));
      store_expect(15, 32'd7, "R11");

      // R12/R10: loads, negative offsets, store then reload
      emit(enc_i(O_LW, 0, 10, CONST_ADDR[15:0]));
      store_expect(10, CONST_VAL, "R12");
      load_const(11, CONST_ADDR + 32'd4);
      emit(enc_i(O_LW, 11, 12, 16'hFFFC));
      store_expect(12, CONST_VAL, "R10");
      emit(enc_i(O_SW, 11, 6, 16'hFFF8));
      emit(enc_i(O_LW, 0, 13, CONST_ADDR[15:0] - 16'd4));
      store_expect(13, 32'd7, "R10");

      // halt: jump to self
      halt_addr = 32'(pw * 4);
      emit(enc_j(O_J, halt_addr));
   endtask

   // watchdog
   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=running expected=halted");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic done;
      build_program();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1/R2: reset state, first fetch
      check("R1", "pc after reset", dbg_pc, 32'h0);
      rst_n = 1'b1;
      #1;
      check("R2", "fetch req", {31'h0, mem_req}, 32'd1);
      check("R2", "fetch we", {31'h0, mem_we}, 32'd0);
      check("R2", "fetch addr", mem_addr, 32'h0);
      @(negedge clk);
      // R3: execute of a non-memory instruction leaves the port idle
      check("R3", "exec req", {31'h0, mem_req}, 32'd0);
      check("R2", "pc held through fetch", dbg_pc, 32'h0);
      @(negedge clk);
      // R4/R1: back to fetch at pc+4
      check("R1", "second fetch req", {31'h0, mem_req}, 32'd1);
      check("R4", "second fetch addr", mem_addr, 32'h4);
      check("R4", "pc after first exec", dbg_pc, 32'h4);

      done = 1'b0;
      for (int c = 0; c < 20000; c++) begin
         @(negedge clk);
         if (dbg_pc == halt_addr) begin
            done = 1'b1;
            break;
         end
      end
      check("R4", "program reached halt", {31'h0, done}, 32'd1);
      repeat (6) @(negedge clk);
      check("R6", "jump to self holds", dbg_pc, halt_addr);

      for (int s = 0; s < slot; s++) begin
         check(expt[s], $sformatf("slot %0d", s), rd_word(RES_BASE + 32'(s * 4)), expv[s]);
      end
      check("R10", "constant word intact", rd_word(CONST_ADDR), CONST_VAL);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule